// File: doc/BRIEF.md
# Interrupt and Exception Delivery Sequencer

This block carries one interrupt or fault from a vector number to the first instruction of its handler. A request names a vector and says whether it is a fault or a plain interrupt. The sequencer then fetches the gate for that vector. In protected mode the gate is an 8-byte entry in the descriptor table. In real mode it is a 4-byte far pointer. When the handler runs at a more privileged level than the current code, the sequencer reads a new stack selector and stack pointer from the task-state record and loads them. It then pushes the return frame through a stack-push port, loads the handler's code selector through a segment-load port, and reports the new instruction pointer and whether the interrupt-enable flag is to be cleared.

Memory reads, segment loads and stack pushes each go through a request/ack port. A port returns either an ack or an error, and an error ends the delivery at once. The sequencer counts faults that have not yet been delivered. A second pending fault is turned into the double-fault vector (8). A third fault asks the core to reset instead of delivering anything. The surrounding core reissues a fault after an abort, which is how nested faults escalate.

Top module: `intr_seq_top`

## Requirements
- R1: In protected mode the gate is read as an 8-byte access (memWide=1) at tableBase + vector*8. Offset bits 15:0 come from gate bits 15:0, the selector from bits 31:16, offset bits 31:16 from bits 63:48, and the type from bits 43:40. Bit 43 set means a 32-bit gate, and bit 40 clear means an interrupt gate rather than a trap gate.
- R2: In real mode the gate is read as a 4-byte access (memWide=0) at tableBase + vector*4. Data bits 15:0 are the offset and bits 31:16 the selector, and the gate acts as a 16-bit interrupt gate.
- R3: When the current privilege exceeds the gate selector's RPL (bits 1:0), an 8-byte record is read at tssBase + 4 + RPL*8. Bits 31:0 of it are the new stack pointer and bits 47:32 the new stack selector. The stack selector is loaded (segIsCode=0), spLoad pulses with the new pointer, and then the old stack selector and the old stack pointer are pushed, in that order.
- R4: The frame pushes flags, then the code selector, then the return pointer, and only after that is the handler selector loaded (segIsCode=1).
- R5: clearIf is 1 after an interrupt gate and 0 after a trap gate.
- R6: A 32-bit gate gives newIp equal to the full gate offset. A 16-bit gate keeps bits 31:16 of the return pointer and replaces bits 15:0 with the offset.
- R7: In protected mode the frame pushes are 32 bits wide (pushWide=1) exactly when the gate is 32-bit. In real mode they are always 16 bits wide, whatever the current code size.
- R8: A fault pushes savedIpIn as the return pointer, and a plain interrupt pushes ipIn.
- R9: After the handler selector is loaded, errCode is pushed only for a fault in protected mode whose delivered vector is 8, 10 to 14 or 17. This push is at the current code size (code32), not the gate size.
- R10: A fault arriving while one earlier fault is still pending is delivered as vector 8. A fault arriving while two are pending produces a resetValid pulse, issues no request, and clears the count.
- R11: A fault delivered successfully clears the pending count, so the next fault keeps its own vector.
- R12: An error on any port produces abortValid without doneValid. No further request is issued, and the fault count is left as it was.
- R13: At most one of memReq, segReq and pushReq is high at a time. Each is held, with stable address or data, until its ack or error arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start a delivery (taken only while not busy) |
| startVector | input | 8 | Requested vector |
| startExc | input | 1 | 1 = fault, 0 = plain interrupt |
| errCode | input | 32 | Error code for faults that carry one |
| protMode | input | 1 | Protected mode enabled |
| curPriv | input | 2 | Current privilege level |
| code32 | input | 1 | Current code segment is 32-bit |
| tableBase | input | 32 | Base of the gate table |
| tssBase | input | 32 | Base of the task-state record |
| flagsIn | input | 32 | Flags value to push |
| csSelIn | input | 16 | Current code selector |
| ipIn | input | 32 | Current instruction pointer |
| savedIpIn | input | 32 | Pointer at the start of the faulting instruction |
| ssSelIn | input | 16 | Current stack selector |
| spIn | input | 32 | Current stack pointer |
| memReq | output | 1 | Memory read request |
| memAddr | output | 32 | Read address |
| memWide | output | 1 | 1 = 8-byte read, 0 = 4-byte read |
| memAck | input | 1 | Read done, memData valid |
| memErr | input | 1 | Read failed |
| memData | input | 64 | Read data |
| segReq | output | 1 | Segment load request |
| segIsCode | output | 1 | 1 = code segment, 0 = stack segment |
| segSel | output | 16 | Selector to load |
| segAck | input | 1 | Segment load done |
| segErr | input | 1 | Segment load failed |
| pushReq | output | 1 | Stack push request |
| pushData | output | 32 | Value to push |
| pushWide | output | 1 | 1 = 32-bit push, 0 = 16-bit push |
| pushAck | input | 1 | Push done |
| pushErr | input | 1 | Push failed |
| busy | output | 1 | A delivery is in progress |
| doneValid | output | 1 | One-cycle pulse: delivery complete |
| abortValid | output | 1 | One-cycle pulse: delivery aborted |
| resetValid | output | 1 | One-cycle pulse: third fault, reset the core |
| newIp | output | 32 | Handler instruction pointer |
| clearIf | output | 1 | Clear the interrupt-enable flag |
| spLoad | output | 1 | One-cycle pulse: load spValue as the stack pointer |
| spValue | output | 32 | New stack pointer from the task-state record |

## Verification
The assertions assume that each ack or error is a one-cycle pulse given only while the matching request is high, that ack and error never arrive together, and that startValid is raised only while busy is low. The bench responders raise a single ack or error one cycle after they see a request, and drop it on the next cycle. Every scenario task waits for doneValid, abortValid or resetValid, and for busy to fall, before it starts the next delivery, so a start is never offered to a busy sequencer.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int SEL_W  = 16;
  localparam int VEC_W  = 8;
  localparam int GATE_W = 64;

  typedef enum logic [3:0] {
    S_IDLE, S_GATE, S_TSS, S_LDSS, S_PSS, S_PSP,
    S_PFL, S_PCS, S_PIP, S_LDCS, S_PERR
  } seqState_t;

  typedef enum logic [2:0] {
    P_OSS, P_OSP, P_FLG, P_CS, P_IP, P_ERR
  } pushSel_t;

  typedef struct packed {
    logic     latchStart;
    logic     latchGate;
    logic     latchTss;
    logic     incCount;
    logic     clrCount;
    logic     memTss;
    logic     segCode;
    pushSel_t pushSel;
  } seqStrobe_t;

  function automatic logic carriesErrCode(input logic [VEC_W-1:0] v);
    return (v == VEC_W'(8)) || ((v >= VEC_W'(10)) && (v <= VEC_W'(14))) ||
           (v == VEC_W'(17));
  endfunction

endpackage

// File: rtl/intr_seq_ctrl.sv
module intr_seq_ctrl
  import intr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       startExc,
  input  logic       atLimit,
  input  logic       gateSwitch,
  input  logic       needErrPush,
  input  logic       curIsExc,
  input  logic       memAck,
  input  logic       memErr,
  input  logic       segAck,
  input  logic       segErr,
  input  logic       pushAck,
  input  logic       pushErr,
  output logic       memReq,
  output logic       segReq,
  output logic       pushReq,
  output logic       busy,
  output seqStrobe_t strobe,
  output logic       doneValid,
  output logic       abortValid,
  output logic       resetValid,
  output logic       spLoad
);

  seqState_t stateQ, stateD;
  logic finishD, abortD, resetD, spLoadD;

  always_comb begin
    stateD         = stateQ;
    strobe         = '0;
    strobe.pushSel = P_FLG;
    finishD        = 1'b0;
    abortD         = 1'b0;
    resetD         = 1'b0;
    spLoadD        = 1'b0;
    unique case (stateQ)
      S_IDLE: begin
        if (startValid) begin
          if (startExc && atLimit) begin
            resetD          = 1'b1;
            strobe.clrCount = 1'b1;
          end else begin
            strobe.latchStart = 1'b1;
            strobe.incCount   = startExc;
            stateD            = S_GATE;
          end
        end
      end
      S_GATE: begin
        if (memErr) abortD = 1'b1;
        else if (memAck) begin
          strobe.latchGate = 1'b1;
          stateD = gateSwitch ? S_TSS : S_PFL;
        end
      end
      S_TSS: begin
        strobe.memTss = 1'b1;
        if (memErr) abortD = 1'b1;
        else if (memAck) begin
          strobe.latchTss = 1'b1;
          stateD = S_LDSS;
        end
      end
      S_LDSS: begin
        if (segErr) abortD = 1'b1;
        else if (segAck) begin
          spLoadD = 1'b1;
          stateD  = S_PSS;
        end
      end
      S_PSS: begin
        strobe.pushSel = P_OSS;
        if (pushErr) abortD = 1'b1;
        else if (pushAck) stateD = S_PSP;
      end
      S_PSP: begin
        strobe.pushSel = P_OSP;
        if (pushErr) abortD = 1'b1;
        else if (pushAck) stateD = S_PFL;
      end
      S_PFL: begin
        strobe.pushSel = P_FLG;
        if (pushErr) abortD = 1'b1;
        else if (pushAck) stateD = S_PCS;
      end
      S_PCS: begin
        strobe.pushSel = P_CS;
        if (pushErr) abortD = 1'b1;
        else if (pushAck) stateD = S_PIP;
      end
      S_PIP: begin
        strobe.pushSel = P_IP;
        if (pushErr) abortD = 1'b1;
        else if (pushAck) stateD = S_LDCS;
      end
      S_LDCS: begin
        strobe.segCode = 1'b1;
        if (segErr) abortD = 1'b1;
        else if (segAck) begin
          if (needErrPush) stateD = S_PERR;
          else finishD = 1'b1;
        end
      end
      S_PERR: begin
        strobe.pushSel = P_ERR;
        if (pushErr) abortD = 1'b1;
        else if (pushAck) finishD = 1'b1;
      end
      default: stateD = S_IDLE;
    endcase
    if (finishD) begin
      stateD          = S_IDLE;
      strobe.clrCount = curIsExc;
    end
    if (abortD) stateD = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= S_IDLE;
      doneValid  <= 1'b0;
      abortValid <= 1'b0;
      resetValid <= 1'b0;
      spLoad     <= 1'b0;
    end else begin
      stateQ     <= stateD;
      doneValid  <= finishD;
      abortValid <= abortD;
      resetValid <= resetD;
      spLoad     <= spLoadD;
    end
  end

  assign memReq  = (stateQ == S_GATE) || (stateQ == S_TSS);
  assign segReq  = (stateQ == S_LDSS) || (stateQ == S_LDCS);
  assign pushReq = (stateQ == S_PSS) || (stateQ == S_PSP) || (stateQ == S_PFL) ||
                   (stateQ == S_PCS) || (stateQ == S_PIP) || (stateQ == S_PERR);
  assign busy    = (stateQ != S_IDLE);

endmodule

// File: rtl/intr_seq_dp.sv
module intr_seq_dp
  import intr_seq_pkg::*;
#(
  parameter int DF_VECTOR   = 8,
  parameter int FAULT_LIMIT = 3,
  localparam int CNT_W      = $clog2(FAULT_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [VEC_W-1:0]  startVector,
  input  logic              startExc,
  input  logic [WORD_W-1:0] errCode,
  input  logic              protMode,
  input  logic [1:0]        curPriv,
  input  logic              code32,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [ADDR_W-1:0] tssBase,
  input  logic [WORD_W-1:0] flagsIn,
  input  logic [SEL_W-1:0]  csSelIn,
  input  logic [WORD_W-1:0] ipIn,
  input  logic [WORD_W-1:0] savedIpIn,
  input  logic [SEL_W-1:0]  ssSelIn,
  input  logic [WORD_W-1:0] spIn,
  input  logic [GATE_W-1:0] memData,
  output logic              atLimit,
  output logic              gateSwitch,
  output logic              needErrPush,
  output logic              curIsExc,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWide,
  output logic              segIsCode,
  output logic [SEL_W-1:0]  segSel,
  output logic [WORD_W-1:0] pushData,
  output logic              pushWide,
  output logic [WORD_W-1:0] newIp,
  output logic              clearIf,
  output logic [WORD_W-1:0] spValue
);

  logic [CNT_W-1:0]  faultCnt;
  logic [VEC_W-1:0]  vecR;
  logic              excR, protR, code32R, gate32R, intGateR;
  logic [1:0]        privR;
  logic [ADDR_W-1:0] tblR, tssR;
  logic [WORD_W-1:0] flagsR, retIpR, errR, oldSpR, offR, newSpR;
  logic [SEL_W-1:0]  csR, oldSsR, gateSelR, newSsR;

  always_ff @(posedge clk) begin
    if (!rstN) faultCnt <= '0;
    else if (strobe.clrCount) faultCnt <= '0;
    else if (strobe.incCount) faultCnt <= faultCnt + CNT_W'(1);
  end

  assign atLimit = (faultCnt == CNT_W'(FAULT_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecR <= '0; excR <= 1'b0; protR <= 1'b0; code32R <= 1'b0; privR <= '0;
      tblR <= '0; tssR <= '0; flagsR <= '0; retIpR <= '0; errR <= '0;
      csR <= '0; oldSsR <= '0; oldSpR <= '0;
    end else if (strobe.latchStart) begin
      vecR    <= (startExc && (faultCnt != '0)) ? VEC_W'(DF_VECTOR) : startVector;
      excR    <= startExc;
      protR   <= protMode;
      code32R <= code32;
      privR   <= curPriv;
      tblR    <= tableBase;
      tssR    <= tssBase;
      flagsR  <= flagsIn;
      retIpR  <= startExc ? savedIpIn : ipIn;
      errR    <= errCode;
      csR     <= csSelIn;
      oldSsR  <= ssSelIn;
      oldSpR  <= spIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offR <= '0; gateSelR <= '0; gate32R <= 1'b0; intGateR <= 1'b0;
    end else if (strobe.latchGate) begin
      gateSelR <= memData[31:16];
      if (protR) begin
        offR     <= {memData[63:48], memData[15:0]};
        gate32R  <= memData[43];
        intGateR <= ~memData[40];
      end else begin
        offR     <= {16'h0000, memData[15:0]};
        gate32R  <= 1'b0;
        intGateR <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newSpR <= '0; newSsR <= '0;
    end else if (strobe.latchTss) begin
      newSpR <= memData[31:0];
      newSsR <= memData[47:32];
    end
  end

  assign gateSwitch  = protR && (privR > memData[17:16]);
  assign needErrPush = protR && excR && carriesErrCode(vecR);
  assign curIsExc    = excR;

  assign memAddr = strobe.memTss ? (tssR + ADDR_W'(4) + ADDR_W'({gateSelR[1:0], 3'b000}))
                 : protR         ? (tblR + (ADDR_W'(vecR) << 3))
                                 : (tblR + (ADDR_W'(vecR) << 2));
  assign memWide = strobe.memTss || protR;

  assign segIsCode = strobe.segCode;
  assign segSel    = strobe.segCode ? gateSelR : newSsR;

  always_comb begin
    unique case (strobe.pushSel)
      P_OSS:   pushData = WORD_W'(oldSsR);
      P_OSP:   pushData = oldSpR;
      P_FLG:   pushData = flagsR;
      P_CS:    pushData = WORD_W'(csR);
      P_IP:    pushData = retIpR;
      P_ERR:   pushData = errR;
      default: pushData = '0;
    endcase
  end

  assign pushWide = (strobe.pushSel == P_ERR) ? code32R : (protR && gate32R);
  assign newIp    = gate32R ? offR : {retIpR[31:16], offR[15:0]};
  assign clearIf  = intGateR;
  assign spValue  = newSpR;

endmodule

// File: rtl/intr_seq_top.sv
module intr_seq_top
  import intr_seq_pkg::*;
#(
  parameter int DF_VECTOR   = 8,
  parameter int FAULT_LIMIT = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic [7:0]  startVector,
  input  logic        startExc,
  input  logic [31:0] errCode,
  input  logic        protMode,
  input  logic [1:0]  curPriv,
  input  logic        code32,
  input  logic [31:0] tableBase,
  input  logic [31:0] tssBase,
  input  logic [31:0] flagsIn,
  input  logic [15:0] csSelIn,
  input  logic [31:0] ipIn,
  input  logic [31:0] savedIpIn,
  input  logic [15:0] ssSelIn,
  input  logic [31:0] spIn,
  output logic        memReq,
  output logic [31:0] memAddr,
  output logic        memWide,
  input  logic        memAck,
  input  logic        memErr,
  input  logic [63:0] memData,
  output logic        segReq,
  output logic        segIsCode,
  output logic [15:0] segSel,
  input  logic        segAck,
  input  logic        segErr,
  output logic        pushReq,
  output logic [31:0] pushData,
  output logic        pushWide,
  input  logic        pushAck,
  input  logic        pushErr,
  output logic        busy,
  output logic        doneValid,
  output logic        abortValid,
  output logic        resetValid,
  output logic [31:0] newIp,
  output logic        clearIf,
  output logic        spLoad,
  output logic [31:0] spValue
);

  seqStrobe_t strobe;
  logic atLimit, gateSwitch, needErrPush, curIsExc;

  intr_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startExc(startExc),
    .atLimit(atLimit), .gateSwitch(gateSwitch), .needErrPush(needErrPush),
    .curIsExc(curIsExc), .memAck(memAck), .memErr(memErr), .segAck(segAck),
    .segErr(segErr), .pushAck(pushAck), .pushErr(pushErr), .memReq(memReq),
    .segReq(segReq), .pushReq(pushReq), .busy(busy), .strobe(strobe),
    .doneValid(doneValid), .abortValid(abortValid), .resetValid(resetValid),
    .spLoad(spLoad)
  );

  intr_seq_dp #(.DF_VECTOR(DF_VECTOR), .FAULT_LIMIT(FAULT_LIMIT)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startVector(startVector),
    .startExc(startExc), .errCode(errCode), .protMode(protMode),
    .curPriv(curPriv), .code32(code32), .tableBase(tableBase),
    .tssBase(tssBase), .flagsIn(flagsIn), .csSelIn(csSelIn), .ipIn(ipIn),
    .savedIpIn(savedIpIn), .ssSelIn(ssSelIn), .spIn(spIn), .memData(memData),
    .atLimit(atLimit), .gateSwitch(gateSwitch), .needErrPush(needErrPush),
    .curIsExc(curIsExc), .memAddr(memAddr), .memWide(memWide),
    .segIsCode(segIsCode), .segSel(segSel), .pushData(pushData),
    .pushWide(pushWide), .newIp(newIp), .clearIf(clearIf), .spValue(spValue)
  );

endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memAck,
  input logic        memErr,
  input logic [31:0] memAddr,
  input logic        segReq,
  input logic        segAck,
  input logic        segErr,
  input logic [15:0] segSel,
  input logic        pushReq,
  input logic        pushAck,
  input logic        pushErr,
  input logic [31:0] pushData,
  input logic        busy,
  input logic        doneValid,
  input logic        abortValid,
  input logic        resetValid
);

  // R13
  single_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({memReq, segReq, pushReq}) <= 1);

  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !memErr) |=> (memReq && $stable(memAddr)));

  // R13
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (segReq && !segAck && !segErr) |=> (segReq && $stable(segSel)));

  // R13
  push_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !pushAck && !pushErr) |=> (pushReq && $stable(pushData)));

  // R12
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortValid |-> (!busy && !memReq && !segReq && !pushReq && !doneValid));

  // R10
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetValid |-> (!busy && !doneValid && !abortValid));

endmodule

bind intr_seq_top intr_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAck(memAck), .memErr(memErr),
  .memAddr(memAddr), .segReq(segReq), .segAck(segAck), .segErr(segErr),
  .segSel(segSel), .pushReq(pushReq), .pushAck(pushAck), .pushErr(pushErr),
  .pushData(pushData), .busy(busy), .doneValid(doneValid),
  .abortValid(abortValid), .resetValid(resetValid)
);

// File: tb/intr_seq_top_tb_top.sv
`timescale 1ns/1ps
module intr_seq_top_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        startValid = 0, startExc = 0, protMode = 0, code32 = 0;
  logic [7:0]  startVector = 0;
  logic [1:0]  curPriv = 0;
  logic [31:0] errCode = 0, tableBase = 0, tssBase = 0, flagsIn = 0;
  logic [31:0] ipIn = 0, savedIpIn = 0, spIn = 0;
  logic [15:0] csSelIn = 0, ssSelIn = 0;
  logic        memReq, memWide, segReq, segIsCode, pushReq, pushWide;
  logic        memAck = 0, memErr = 0, segAck = 0, segErr = 0, pushAck = 0, pushErr = 0;
  logic [63:0] memData = 0;
  logic [31:0] memAddr, pushData, newIp, spValue;
  logic [15:0] segSel;
  logic        busy, doneValid, abortValid, resetValid, clearIf, spLoad;

  intr_seq_top dut_i (.*);

  int nChk = 0, nFail = 0;
  int evN = 0, pushN = 0, failAt = -1, outcome = 0;
  int          evKind [16];
  logic [63:0] evVal [16];
  logic        evWide [16];
  logic [31:0] expGateAddr, expTssAddr;
  logic [63:0] gateWord, tssWord;
  logic        spSeen;
  logic [31:0] spVal;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chkEv(input string req, input int idx, input int kind, input logic [63:0] val, input logic wide);
    chk(req, $sformatf("event %0d kind", idx), 64'(evKind[idx]), 64'(kind));
    chk(req, $sformatf("event %0d value", idx), evVal[idx], val);
    chk(req, $sformatf("event %0d width/code", idx), 64'(evWide[idx]), 64'(wide));
  endtask

  // Responders: kind 0 = mem read, 1 = segment load, 2 = push
  initial begin
    forever begin
      @(negedge clk);
      if (spLoad) begin spSeen = 1; spVal = spValue; end
      if (memAck || memErr || segAck || segErr || pushAck || pushErr) begin
        memAck = 0; memErr = 0; segAck = 0; segErr = 0; pushAck = 0; pushErr = 0;
      end else if (memReq) begin
        if (evN < 16) begin evKind[evN] = 0; evVal[evN] = 64'(memAddr); evWide[evN] = memWide; evN++; end
        if (memAddr == expGateAddr) begin memData = gateWord; memAck = 1; end
        else if (memAddr == expTssAddr) begin memData = tssWord; memAck = 1; end
        else memErr = 1;
      end else if (segReq) begin
        if (evN < 16) begin evKind[evN] = 1; evVal[evN] = 64'(segSel); evWide[evN] = segIsCode; evN++; end
        segAck = 1;
      end else if (pushReq) begin
        if (evN < 16) begin evKind[evN] = 2; evVal[evN] = 64'(pushData); evWide[evN] = pushWide; evN++; end
        if (pushN == failAt) pushErr = 1; else pushAck = 1;
        pushN++;
      end
    end
  end

  function automatic logic [63:0] mkGate(input logic [31:0] off, input logic [15:0] sel, input logic [3:0] typ);
    return {off[31:16], 1'b1, 2'b00, 1'b0, typ, 8'h00, sel, off[15:0]};
  endfunction

  task automatic deliver(input logic [7:0] vec, input logic exc);
    evN = 0; pushN = 0; spSeen = 0; outcome = 0;
    @(negedge clk);
    startVector = vec; startExc = exc; startValid = 1;
    @(negedge clk);
    startValid = 0;
    for (int i = 0; i < 200 && outcome == 0; i++) begin
      if (doneValid) outcome = 1;
      else if (abortValid) outcome = 2;
      else if (resetValid) outcome = 3;
      if (outcome == 0) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic setCommon(input logic prot, input logic c32, input logic [1:0] cpl);
    protMode = prot; code32 = c32; curPriv = cpl; failAt = -1;
    tableBase = 32'h0000_1000; tssBase = 32'h0000_2000;
    flagsIn = 32'h0000_0202; csSelIn = 16'h0008; ipIn = 32'hAAAA_0010;
    savedIpIn = 32'hBBBB_0020; ssSelIn = 16'h002B; spIn = 32'h0000_7FF0;
    errCode = 32'h0000_001C; expTssAddr = 32'hFFFF_FFF0; tssWord = 0;
  endtask

  task automatic testReset();
    chk("R13", "reset memReq", 64'(memReq), 0);
    chk("R13", "reset pushReq", 64'(pushReq), 0);
    chk("R12", "reset busy", 64'(busy), 0);
  endtask

  task automatic testProt32Int();
    setCommon(1, 1, 0);
    expGateAddr = 32'h1000 + 32'h21 * 8;
    gateWord = mkGate(32'h1234_5678, 16'h0010, 4'hE);
    deliver(8'h21, 0);
    chk("R4", "outcome", 64'(outcome), 1);
    chk("R1", "event count", 64'(evN), 5);
    chkEv("R1", 0, 0, 64'h1108, 1);
    chkEv("R4", 1, 2, 64'h202, 1);
    chkEv("R4", 2, 2, 64'h8, 1);
    chkEv("R8", 3, 2, 64'hAAAA_0010, 1);
    chkEv("R4", 4, 1, 64'h10, 1);
    chk("R6", "newIp 32-bit gate", 64'(newIp), 64'h1234_5678);
    chk("R5", "interrupt gate clears IF", 64'(clearIf), 1);
  endtask

  task automatic testProt16Trap();
    setCommon(1, 1, 0);
    expGateAddr = 32'h1000 + 32'h30 * 8;
    gateWord = mkGate(32'h5555_BEEF, 16'h0018, 4'h7);
    deliver(8'h30, 0);
    chk("R7", "event count", 64'(evN), 5);
    chkEv("R7", 1, 2, 64'h202, 0);
    chkEv("R7", 3, 2, 64'hAAAA_0010, 0);
    chk("R6", "newIp 16-bit gate", 64'(newIp), 64'hAAAA_BEEF);
    chk("R5", "trap gate keeps IF", 64'(clearIf), 0);
  endtask

  task automatic testPrivSwitch();
    setCommon(1, 1, 3);
    expGateAddr = 32'h1000 + 32'h40 * 8;
    gateWord = mkGate(32'h0040_0000, 16'h0029, 4'hE);
    expTssAddr = 32'h2000 + 4 + 8;
    tssWord = {16'h0, 16'h0033, 32'h0008_F000};
    deliver(8'h40, 0);
    chk("R3", "outcome", 64'(outcome), 1);
    chk("R3", "event count", 64'(evN), 9);
    chkEv("R3", 1, 0, 64'h200C, 1);
    chkEv("R3", 2, 1, 64'h33, 0);
    chkEv("R3", 3, 2, 64'h2B, 1);
    chkEv("R3", 4, 2, 64'h7FF0, 1);
    chkEv("R4", 5, 2, 64'h202, 1);
    chkEv("R4", 8, 1, 64'h29, 1);
    chk("R3", "spLoad seen", 64'(spSeen), 1);
    chk("R3", "spLoad value", 64'(spVal), 64'h0008_F000);
  endtask

  task automatic testReal();
    setCommon(0, 1, 0);
    tableBase = 0;
    expGateAddr = 32'h10 * 4;
    gateWord = {32'hDEAD_BEEF, 16'hF000, 16'h1234};
    deliver(8'h10, 0);
    chk("R2", "event count", 64'(evN), 5);
    chkEv("R2", 0, 0, 64'h40, 0);
    chkEv("R7", 1, 2, 64'h202, 0);
    chkEv("R7", 3, 2, 64'hAAAA_0010, 0);
    chkEv("R2", 4, 1, 64'hF000, 1);
    chk("R2", "newIp low half replaced", 64'(newIp), 64'hAAAA_1234);
    chk("R2", "real mode clears IF", 64'(clearIf), 1);
  endtask

  task automatic testErrPush();
    setCommon(1, 0, 0);
    expGateAddr = 32'h1000 + 13 * 8;
    gateWord = mkGate(32'h0010_0000, 16'h0010, 4'hE);
    deliver(8'd13, 1);
    chk("R9", "event count", 64'(evN), 6);
    chkEv("R8", 3, 2, 64'hBBBB_0020, 1);
    chkEv("R9", 4, 1, 64'h10, 1);
    chkEv("R9", 5, 2, 64'h1C, 0);
    // R11: count cleared, vector 14 keeps its own vector
    expGateAddr = 32'h1000 + 14 * 8;
    deliver(8'd14, 1);
    chkEv("R11", 0, 0, 64'(32'h1000 + 14 * 8), 1);
    chk("R11", "outcome", 64'(outcome), 1);
  endtask

  task automatic testRealNoErr();
    setCommon(0, 0, 0);
    expGateAddr = 32'h1000 + 13 * 4;
    gateWord = {32'h0, 16'h2000, 16'h0100};
    deliver(8'd13, 1);
    chk("R9", "real mode: no error push, event count", 64'(evN), 5);
    chk("R9", "outcome", 64'(outcome), 1);
  endtask

  task automatic testEscalate();
    setCommon(1, 1, 0);
    expGateAddr = 32'h1000 + 13 * 8;
    gateWord = mkGate(32'h0010_0000, 16'h0010, 4'hE);
    failAt = 0;
    deliver(8'd13, 1);
    chk("R12", "first abort outcome", 64'(outcome), 2);
    chk("R12", "no request after push error", 64'(evN), 2);
    expGateAddr = 32'h1000 + 8 * 8;
    failAt = 0;
    deliver(8'd13, 1);
    chk("R10", "second fault outcome", 64'(outcome), 2);
    chkEv("R10", 0, 0, 64'h1040, 1);
    deliver(8'd13, 1);
    chk("R10", "third fault resets", 64'(outcome), 3);
    chk("R10", "no requests on reset", 64'(evN), 0);
    failAt = -1;
    expGateAddr = 32'h1000 + 6 * 8;
    deliver(8'd6, 1);
    chk("R10", "count cleared by reset", 64'(outcome), 1);
    chk("R9", "vector 6 has no error push", 64'(evN), 5);
    // R12: memory error on gate read
    expGateAddr = 32'hFFFF_0000;
    deliver(8'h22, 0);
    chk("R12", "gate read error aborts", 64'(outcome), 2);
    chk("R12", "nothing after read error", 64'(evN), 1);
  endtask

  bit finished = 0;
  initial begin
    #(8 * 150000);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    expGateAddr = 0; gateWord = 0; expTssAddr = 0; tssWord = 0; spSeen = 0; spVal = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testProt32Int();
    testProt16Trap();
    testPrivSwitch();
    testReal();
    testErrPush();
    testRealNoErr();
    testEscalate();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule